// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and the calendar date in packed BCD registers. A one-cycle `tick` strobe, produced elsewhere once per second, advances the seconds register. Each register that wraps passes a carry to the next one in the same clock cycle, so a single tick can roll everything from seconds up to the year. The block runs on one system clock, and `tick` acts as an enable on that clock.

The hours register supports a 24-hour format and a 12-hour format. A mode bit inside the hours register selects the format, and in 12-hour format a second bit inside the same register flags afternoon. Month lengths are applied without software help, including February 29 in leap years, using only the two-digit year. Software can load any register through a synchronous write port and can read any register through a read port that has one cycle of latency. The block does not check written values for BCD validity. Counting simply continues from whatever was written.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the registers hold seconds 0x00, minutes 0x00, hours 0x00 (24-hour, midnight), weekday 0x01, date 0x01, month 0x01 and year 0x00. Their addresses are seconds 0, minutes 1, hours 2, weekday 3, date 4, month 5 and year 6.
- R2: A write with `wr_en` high replaces the addressed register at the next clock edge. `rd_data` shows the register selected by `rd_addr` one clock edge later. Address 7 always reads 0x00, and writes to address 7 change nothing.
- R3: Seconds and minutes count 0x00 to 0x59 and return to 0x00. Each return carries into the next register in the same cycle.
- R4: With hours bit 7 clear (24-hour format), bits 5:0 count 0x00 to 0x23. The step from 0x23 to 0x00 carries into the weekday and the date.
- R5: With hours bit 7 set (12-hour format), bit 5 means afternoon and bits 4:0 hold the hour. The hour counts 0x12, 0x01, 0x02 and so on up to 0x11. The step from 0x11 to 0x12 toggles bit 5. Only the step from 0x11 with bit 5 set carries into the weekday and the date.
- R6: The weekday counts 0x01 to 0x07 and returns to 0x01.
- R7: The date returns to 0x01 after the last day of the month: 0x30 for months 0x04, 0x06, 0x09 and 0x11, and 0x31 for the other months apart from February. That return advances the month. The month returns from 0x12 to 0x01 and advances the year. The year returns from 0x99 to 0x00.
- R8: February ends at 0x29 when the BCD year is a multiple of four, with 0x00 counting as one, and at 0x28 otherwise.
- R9: If a write and a tick land in the same cycle, the written register takes the write data. It neither steps nor carries. The other registers advance as normal.
- R10: A step that does not wrap works on the whole byte. A low nibble of 9 becomes 0 and the high nibble gains one. Any other low nibble gains one, modulo 16. A wrap happens only on an exact match with the limit. Invalid digits are never corrected.
- R11: In cycles without a tick and without a write, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address for writes |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register address for reads |
| rd_data | output | 8 | Registered read data |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 3-bit address, the 12-hour format enabled and automatic leap-year handling enabled. With these settings both hour formats, the February 29 limit and the unmapped eighth address slot can all be reached. Directed cases drive every roll-over chain, from a single second up to the end of the century. Random loads, including invalid BCD bytes and writes that collide with ticks, are compared against a reference model inside the bench.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int F_SEC    = 0;
   localparam int F_MIN    = 1;
   localparam int F_HOUR   = 2;
   localparam int F_DOW    = 3;
   localparam int F_DATE   = 4;
   localparam int F_MON    = 5;
   localparam int F_YEAR   = 6;
   localparam int N_FIELDS = 7;

   // Whole-byte BCD step: a low digit of 9 clears and bumps the high digit
   function automatic logic [7:0] bcd_step(input logic [7:0] v);
      logic [3:0] lo;
      logic [3:0] hi;
      lo = v[3:0];
      hi = v[7:4];
      if (lo == 4'h9) bcd_step = {hi + 4'h1, 4'h0};
      else            bcd_step = {hi, lo + 4'h1};
   endfunction

   // Last value before a register wraps
   function automatic logic [7:0] field_limit(input int idx);
      case (idx)
         F_SEC, F_MIN: field_limit = 8'h59;
         F_DOW:        field_limit = 8'h07;
         F_MON:        field_limit = 8'h12;
         F_YEAR:       field_limit = 8'h99;
         default:      field_limit = 8'h31;
      endcase
   endfunction

   // Value after a wrap, also the reset value
   function automatic logic [7:0] field_base(input int idx);
      case (idx)
         F_DOW, F_DATE, F_MON: field_base = 8'h01;
         default:              field_base = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
   import rtc_cal_pkg::*;
#(
   parameter int          DATA_W = 8,
   parameter logic [7:0]  BASE   = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] lim,
   output logic [DATA_W-1:0] q,
   output logic              carry
);

   logic at_lim;
   assign at_lim = (q == lim);
   assign carry  = inc & ~wr & at_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= BASE;
      else if (wr)    q <= wdata;
      else if (inc)   q <= at_lim ? BASE : bcd_step(q);
   end

   AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> q == $past(wdata)); // R2

   AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr && q == lim) |=> q == BASE); // R3

   AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !wr) |=> $stable(q)); // R11

endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field
   import rtc_cal_pkg::*;
#(
   parameter bit HAS_12H = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       wr,
   input  logic [7:0] wdata,
   output logic [7:0] q,
   output logic       carry
);

   logic       fmt12;
   logic [7:0] nxt;
   logic       roll;

   generate
      if (HAS_12H) begin : g_fmt_sel
         assign fmt12 = q[7];
      end else begin : g_fmt_fixed
         assign fmt12 = 1'b0;
      end
   endgenerate

   always_comb begin
      nxt  = bcd_step(q);
      roll = 1'b0;
      if (fmt12) begin
         if (q[4:0] == 5'h12) begin
            nxt = {q[7:5], 5'h01};
         end else if (q[4:0] == 5'h11) begin
            nxt  = {q[7:6], ~q[5], 5'h12};
            roll = q[5];
         end
      end else if (q[5:0] == 6'h23) begin
         nxt  = {q[7:6], 6'h00};
         roll = 1'b1;
      end
   end

   assign carry = inc & ~wr & roll;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 8'h00;
      else if (wr)  q <= wdata;
      else if (inc) q <= nxt;
   end

   AST_H24_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr && !q[7] && q[5:0] == 6'h23) |=> q[5:0] == 6'h00); // R4

   generate
      if (HAS_12H) begin : g_chk12
         AST_PM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
            (inc && !wr && q[7] && q[4:0] == 5'h11) |=> q[5] != $past(q[5])); // R5
      end
   endgenerate

endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len #(
   parameter bit LEAP_AUTO = 1'b1
) (
   input  logic [7:0] month,
   input  logic [4:0] year_lo,
   output logic [7:0] last_day
);

   logic leap;

   generate
      if (LEAP_AUTO) begin : g_leap
         // BCD multiple of four: even tens with 0/4/8, odd tens with 2/6
         always_comb begin
            if (!year_lo[4]) leap = (year_lo[3:0] == 4'h0) || (year_lo[3:0] == 4'h4) ||
                                    (year_lo[3:0] == 4'h8);
            else             leap = (year_lo[3:0] == 4'h2) || (year_lo[3:0] == 4'h6);
         end
      end else begin : g_noleap
         assign leap = 1'b0;
      end
   endgenerate

   always_comb begin
      case (month)
         8'h02:                      last_day = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
         default:                    last_day = 8'h31;
      endcase
   end

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
   import rtc_cal_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 3,
   parameter bit HAS_12H   = 1'b1,
   parameter bit LEAP_AUTO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int N_SLOT = 1 << ADDR_W;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("rtc_bcd_calendar: DATA_W must be 8");
      end
      if (N_SLOT < N_FIELDS) begin : g_bad_addr
         $error("rtc_bcd_calendar: ADDR_W too small for all registers");
      end
   endgenerate

   logic [DATA_W-1:0] q_v     [N_SLOT];
   logic              carry_v [N_FIELDS];
   logic              inc_v   [N_FIELDS];
   logic [7:0]        date_last;

   assign inc_v[F_SEC]  = tick;
   assign inc_v[F_MIN]  = carry_v[F_SEC];
   assign inc_v[F_HOUR] = carry_v[F_MIN];
   assign inc_v[F_DOW]  = carry_v[F_HOUR];
   assign inc_v[F_DATE] = carry_v[F_HOUR];
   assign inc_v[F_MON]  = carry_v[F_DATE];
   assign inc_v[F_YEAR] = carry_v[F_MON];

   rtc_month_len #(.LEAP_AUTO(LEAP_AUTO)) i_month_len (
      .month    (q_v[F_MON]),
      .year_lo  (q_v[F_YEAR][4:0]),
      .last_day (date_last)
   );

   generate
      for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
         if (i == F_HOUR) begin : g_hour
            rtc_hour_field #(.HAS_12H(HAS_12H)) i_hour (
               .clk   (clk),
               .rst_n (rst_n),
               .inc   (inc_v[i]),
               .wr    (wr_en && (wr_addr == ADDR_W'(i))),
               .wdata (wr_data),
               .q     (q_v[i]),
               .carry (carry_v[i])
            );
         end else if (i < N_FIELDS) begin : g_cnt
            logic [DATA_W-1:0] lim;
            if (i == F_DATE) begin : g_var_lim
               assign lim = date_last;
            end else begin : g_const_lim
               assign lim = field_limit(i);
            end
            rtc_bcd_field #(.DATA_W(DATA_W), .BASE(field_base(i))) i_field (
               .clk   (clk),
               .rst_n (rst_n),
               .inc   (inc_v[i]),
               .wr    (wr_en && (wr_addr == ADDR_W'(i))),
               .wdata (wr_data),
               .lim   (lim),
               .q     (q_v[i]),
               .carry (carry_v[i])
            );
         end else begin : g_empty
            assign q_v[i] = '0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= q_v[rd_addr];
   end

   AST_SEC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(wr_en && wr_addr == ADDR_W'(F_SEC))) |=> q_v[F_SEC] != $past(q_v[F_SEC])); // R3

   AST_DOW_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
      carry_v[F_DOW] |=> q_v[F_DOW] == 8'h01); // R6

   AST_YEAR_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
      carry_v[F_YEAR] |=> q_v[F_YEAR] == 8'h00); // R7

endmodule

// File: tb/test_rtc_bcd_calendar.sv
module test_rtc_bcd_calendar;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;

   logic [7:0] m  [7];
   logic [7:0] mo [7];

   always #4 clk = ~clk;

   rtc_bcd_calendar i_rtc_bcd_calendar (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   function automatic logic [7:0] bstep(input logic [7:0] v);
      if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
      return {v[7:4], v[3:0] + 4'h1};
   endfunction

   function automatic logic [7:0] month_end(input logic [7:0] mon, input logic [7:0] yr);
      bit lp;
      lp = yr[4] ? (yr[3:0] == 4'h2 || yr[3:0] == 4'h6)
                 : (yr[3:0] == 4'h0 || yr[3:0] == 4'h4 || yr[3:0] == 4'h8);
      if (mon == 8'h02) return lp ? 8'h29 : 8'h28;
      if (mon == 8'h04 || mon == 8'h06 || mon == 8'h09 || mon == 8'h11) return 8'h30;
      return 8'h31;
   endfunction

   function automatic logic [7:0] to_bcd(input int n);
      return {4'(n / 10), 4'(n % 10)};
   endfunction

   // generic register model step; returns carry out
   function automatic bit fld(input int i, input bit inc, input logic [7:0] lim,
                              input logic [7:0] base, input bit we, input int wa,
                              input logic [7:0] wd);
      if (we && wa == i) begin m[i] = wd; return 1'b0; end
      if (!inc) return 1'b0;
      if (mo[i] == lim) begin m[i] = base; return 1'b1; end
      m[i] = bstep(mo[i]);
      return 1'b0;
   endfunction

   task automatic model_apply(input bit t, input bit we, input int wa, input logic [7:0] wd);
      bit cs, cm, ch, cd, cmo, cy;
      for (int i = 0; i < 7; i++) mo[i] = m[i];
      cs = fld(0, t, 8'h59, 8'h00, we, wa, wd);
      cm = fld(1, cs, 8'h59, 8'h00, we, wa, wd);
      ch = 1'b0;
      if (we && wa == 2) m[2] = wd;
      else if (cm) begin
         if (mo[2][7]) begin
            if (mo[2][4:0] == 5'h12) m[2] = {mo[2][7:5], 5'h01};
            else if (mo[2][4:0] == 5'h11) begin
               m[2] = {mo[2][7:6], ~mo[2][5], 5'h12};
               ch = mo[2][5];
            end else m[2] = bstep(mo[2]);
         end else if (mo[2][5:0] == 6'h23) begin
            m[2] = {mo[2][7:6], 6'h00};
            ch = 1'b1;
         end else m[2] = bstep(mo[2]);
      end
      void'(fld(3, ch, 8'h07, 8'h01, we, wa, wd));
      cd  = fld(4, ch, month_end(mo[5], mo[6]), 8'h01, we, wa, wd);
      cmo = fld(5, cd, 8'h12, 8'h01, we, wa, wd);
      cy  = fld(6, cmo, 8'h99, 8'h00, we, wa, wd);
      if (cy) m[6] = m[6];
   endtask

   task automatic cyc(input bit t, input bit we, input int wa, input logic [7:0] wd);
      tick = t; wr_en = we; wr_addr = wa[2:0]; wr_data = wd;
      @(posedge clk);
      model_apply(t, we, wa, wd);
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
   endtask

   task automatic chk(input int a, input logic [7:0] exp, input string tag);
      rd_addr = a[2:0];
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (rd_data !== exp) begin
         errors++;
         $display("FAIL %s addr %0d actual %h expected %h", tag, a, rd_data, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      for (int a = 0; a < 7; a++) chk(a, m[a], tag);
   endtask

   task automatic load(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                       input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mn,
                       input logic [7:0] y);
      cyc(0, 1, 0, s);  cyc(0, 1, 1, mi); cyc(0, 1, 2, h);
      cyc(0, 1, 3, dw); cyc(0, 1, 4, dt); cyc(0, 1, 5, mn); cyc(0, 1, 6, y);
   endtask

   function automatic logic [7:0] rand_val(input int f);
      int r;
      r = int'($urandom % 16);
      if (r == 0) return 8'($urandom);
      case (f)
         0, 1: return (($urandom % 2) == 0) ? to_bcd(int'(55 + $urandom % 5)) : to_bcd(int'($urandom % 60));
         2: begin
            if (($urandom % 2) == 0) return to_bcd(int'($urandom % 24));
            return 8'h80 | (8'($urandom % 2) << 5) | to_bcd(int'(1 + $urandom % 12));
         end
         3: return to_bcd(int'(1 + $urandom % 7));
         4: return to_bcd(int'(26 + $urandom % 6));
         5: return to_bcd(int'(1 + $urandom % 12));
         default: return to_bcd(int'($urandom % 100));
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240229));
      m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h01;
      m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(0, 8'h00, "R1"); chk(1, 8'h00, "R1"); chk(2, 8'h00, "R1"); chk(3, 8'h01, "R1");
      chk(4, 8'h01, "R1"); chk(5, 8'h01, "R1"); chk(6, 8'h00, "R1");

      // R11 idle cycles change nothing
      repeat (6) cyc(0, 0, 0, 8'h00);
      chk_all("R11");

      // R2 write, read and the unmapped slot
      cyc(0, 1, 7, 8'hFF);
      chk(7, 8'h00, "R2");
      chk_all("R2");
      cyc(0, 1, 0, 8'h42);
      chk(0, 8'h42, "R2");

      // R3 seconds and minutes roll
      load(8'h59, 8'h59, 8'h05, 8'h02, 8'h10, 8'h03, 8'h21);
      cyc(1, 0, 0, 8'h00);
      chk(0, 8'h00, "R3"); chk(1, 8'h00, "R3"); chk(2, 8'h06, "R3");

      // R4 and R6 midnight in 24-hour format
      load(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h06, 8'h21);
      cyc(1, 0, 0, 8'h00);
      chk(2, 8'h00, "R4"); chk(3, 8'h01, "R6"); chk(4, 8'h16, "R4");

      // R5 12-hour format
      load(8'h59, 8'h59, 8'h91, 8'h03, 8'h10, 8'h03, 8'h21);
      cyc(1, 0, 0, 8'h00);
      chk(2, 8'hB2, "R5"); chk(3, 8'h03, "R5");
      load(8'h59, 8'h59, 8'hB2, 8'h03, 8'h10, 8'h03, 8'h21);
      cyc(1, 0, 0, 8'h00);
      chk(2, 8'hA1, "R5");
      load(8'h59, 8'h59, 8'hB1, 8'h03, 8'h10, 8'h03, 8'h21);
      cyc(1, 0, 0, 8'h00);
      chk(2, 8'h92, "R5"); chk(3, 8'h04, "R5"); chk(4, 8'h11, "R5");

      // R7 month and year roll
      load(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
      cyc(1, 0, 0, 8'h00);
      chk(4, 8'h01, "R7"); chk(5, 8'h01, "R7"); chk(6, 8'h00, "R7");
      load(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h21);
      cyc(1, 0, 0, 8'h00);
      chk(4, 8'h01, "R7"); chk(5, 8'h05, "R7");

      // R8 leap years
      load(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
      cyc(1, 0, 0, 8'h00);
      chk(4, 8'h29, "R8"); chk(5, 8'h02, "R8");
      load(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
      cyc(1, 0, 0, 8'h00);
      chk(4, 8'h01, "R8"); chk(5, 8'h03, "R8");
      load(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
      cyc(1, 0, 0, 8'h00);
      chk(4, 8'h01, "R8");
      load(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
      cyc(1, 0, 0, 8'h00);
      chk(4, 8'h29, "R8");
      load(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h10);
      cyc(1, 0, 0, 8'h00);
      chk(4, 8'h01, "R8");
      load(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h12);
      cyc(1, 0, 0, 8'h00);
      chk(4, 8'h29, "R8");

      // R9 write collides with tick
      load(8'h59, 8'h10, 8'h04, 8'h01, 8'h05, 8'h05, 8'h21);
      cyc(1, 1, 0, 8'h30);
      chk(0, 8'h30, "R9"); chk(1, 8'h10, "R9");
      cyc(1, 1, 1, 8'h44);
      chk(0, 8'h31, "R9"); chk(1, 8'h44, "R9");

      // R10 invalid digits carry on
      cyc(0, 1, 0, 8'h5A);
      cyc(1, 0, 0, 8'h00);
      chk(0, 8'h5B, "R10");
      cyc(0, 1, 0, 8'h69);
      cyc(1, 0, 0, 8'h00);
      chk(0, 8'h70, "R10");
      chk_all("R10");

      // random mix against the model
      for (int it = 0; it < 500; it++) begin
         int r;
         r = int'($urandom % 10);
         if (r < 4) begin
            int f;
            f = int'($urandom % 8);
            cyc(($urandom % 4) == 0, 1, f, rand_val(f));
         end else if (r < 9) begin
            int n;
            n = int'(1 + $urandom % 40);
            for (int k = 0; k < n; k++) cyc(($urandom % 8) != 0, 0, 0, 8'h00);
         end else begin
            chk_all("R7 random");
         end
      end
      chk_all("R7 random");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule